// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Aggregator

This block gathers the event conditions of six USB device endpoints (numbered 0 to 5) into a six-bit status register and raises one level-sensitive interrupt request for the whole controller. Each endpoint's control/status logic supplies level signals. The aggregator detects the transition that counts as an event for each signal and sets that endpoint's status bit, unless the endpoint's mask bit is set. A set mask bit stops the status bit from being set at all. It does not merely hide the bit from the interrupt line.

Software reaches the block through a small register port. Address 0 holds the status register, where writing a 1 clears a bit. Address 1 holds the mask register, which is written directly. The interrupt request stays high while any status bit is 1. An interrupt handler therefore reads the status, services the endpoints it finds, and clears those bits last.

Top module: `usb_ep_irq_agg`

## Requirements
- R1: `irq` is high exactly when at least one bit of `statusOut` is 1, and it stays high until every set bit has been cleared.
- R2: After reset, `statusOut` is 0, `irq` is 0 and the mask register reads 6'h3F, so every endpoint is masked.
- R3: While mask bit n is 1, no event can set status bit n. The mask value that applies is the one held before the clock edge.
- R4: A write to address 0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged.
- R5: Status bit 0 sets on a rising edge of `ep0OutReady`, on a falling edge of `ep0InReady`, or on a rising edge of `ep0SentStall`.
- R6: Status bit 1 sets on a rising edge of `ep1InDone`. Status bit 5 sets on a rising edge of `ep5InDone`. Status bit 2 sets on a rising edge of `ep2OutReady`.
- R7: Status bit 3 sets on a rising edge of `ep3InDone` or of `ep3Underrun`. Status bit 4 sets on a rising edge of `ep4OutReady`, of `ep4Overflow` or of `ep4IsoErr`.
- R8: A condition that stays at its active level creates only one event. After software clears the bit, the held condition does not set it again.
- R9: When an event and a write-one-to-clear reach the same status bit on the same clock edge, the bit ends up set.
- R10: Clearing a mask bit does not set the status bit, even while that endpoint's condition is held high. Only a later event sets it.
- R11: `regRdData` returns the status register when `regAddr` is 0 and the mask register when `regAddr` is 1. Bit n of either register belongs to endpoint n. A mask write takes effect on the clock edge at which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ep0OutReady | input | 1 | Endpoint 0 OUT packet ready level |
| ep0InReady | input | 1 | Endpoint 0 IN packet ready level (event on falling edge) |
| ep0SentStall | input | 1 | Endpoint 0 STALL handshake sent level |
| ep1InDone | input | 1 | Endpoint 1 IN packet complete |
| ep2OutReady | input | 1 | Endpoint 2 OUT packet received |
| ep3InDone | input | 1 | Endpoint 3 IN packet complete |
| ep3Underrun | input | 1 | Endpoint 3 transmit underrun |
| ep4OutReady | input | 1 | Endpoint 4 OUT packet received |
| ep4Overflow | input | 1 | Endpoint 4 receive overflow |
| ep4IsoErr | input | 1 | Endpoint 4 isochronous error flag |
| ep5InDone | input | 1 | Endpoint 5 IN packet complete |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 mask |
| regWrData | input | 6 | Register write data |
| regRdData | output | 6 | Register read data for the register selected by `regAddr` |
| statusOut | output | 6 | Status register contents |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The bench drives an event and a write-one-to-clear onto the same bit on the same edge. A design that gave the clear priority would lose that event. It also holds conditions high across a clear and across an unmask. A design that tested levels rather than edges would set the bit again at once, or would raise an interrupt as soon as the mask dropped. The endpoint 0 IN-ready condition is checked on its falling edge, which catches a detector wired with the wrong polarity. A partial clear pattern catches a design that clears bits written with 0. Random stimulus compared against a bench model covers events that arrive while the mask is changing.

// File: rtl/usb_irq_agg_pkg.sv
package usb_irq_agg_pkg;
  localparam int NUM_EP   = 6;
  localparam int NUM_COND = 11;

  // Condition vector positions
  localparam int C_EP0_OUT   = 0;
  localparam int C_EP0_IN    = 1;
  localparam int C_EP0_STALL = 2;
  localparam int C_EP1_IN    = 3;
  localparam int C_EP2_OUT   = 4;
  localparam int C_EP3_IN    = 5;
  localparam int C_EP3_UND   = 6;
  localparam int C_EP4_OUT   = 7;
  localparam int C_EP4_OVF   = 8;
  localparam int C_EP4_ISO   = 9;
  localparam int C_EP5_IN    = 10;

  // Conditions whose event is the falling edge
  localparam logic [NUM_COND-1:0] FALL_SEL = NUM_COND'(1) << C_EP0_IN;

  typedef struct packed {
    logic [NUM_EP-1:0] setReq;
    logic [NUM_EP-1:0] clrBits;
    logic              maskWr;
    logic [NUM_EP-1:0] maskData;
  } ctlStrobes_t;
endpackage

// File: rtl/usb_irq_edge_det.sv
module usb_irq_edge_det #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] FALL_MASK = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] pulse
);
  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= lvl;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (FALL_MASK[i]) begin : g_fall
      assign pulse[i] = prevQ[i] & ~lvl[i];
    end else begin : g_rise
      assign pulse[i] = lvl[i] & ~prevQ[i];
    end
  end
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_agg_pkg::*;
(
  input  logic                condPulse [NUM_COND],
  input  logic                regWrEn,
  input  logic                regAddr,
  input  logic [NUM_EP-1:0]   regWrData,
  output ctlStrobes_t         strobes
);
  logic wrStatus;
  logic wrMask;

  assign wrStatus = regWrEn & ~regAddr;
  assign wrMask   = regWrEn &  regAddr;

  always_comb begin
    strobes.setReq[0] = condPulse[C_EP0_OUT] | condPulse[C_EP0_IN] | condPulse[C_EP0_STALL];
    strobes.setReq[1] = condPulse[C_EP1_IN];
    strobes.setReq[2] = condPulse[C_EP2_OUT];
    strobes.setReq[3] = condPulse[C_EP3_IN] | condPulse[C_EP3_UND];
    strobes.setReq[4] = condPulse[C_EP4_OUT] | condPulse[C_EP4_OVF] | condPulse[C_EP4_ISO];
    strobes.setReq[5] = condPulse[C_EP5_IN];
    strobes.clrBits   = wrStatus ? regWrData : '0;
    strobes.maskWr    = wrMask;
    strobes.maskData  = regWrData;
  end
endmodule

// File: rtl/usb_irq_datapath.sv
module usb_irq_datapath
  import usb_irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              regAddr,
  output logic [NUM_EP-1:0] statusQ,
  output logic [NUM_EP-1:0] maskQ,
  output logic [NUM_EP-1:0] rdData,
  output logic              irqOut
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '1;
    end else begin
      // a set in the same cycle overrides a clear
      statusQ <= (statusQ & ~strobes.clrBits) | (strobes.setReq & ~maskQ);
      if (strobes.maskWr) maskQ <= strobes.maskData;
    end
  end

  assign rdData = regAddr ? maskQ : statusQ;
  assign irqOut = |statusQ;
endmodule

// File: rtl/usb_ep_irq_agg.sv
module usb_ep_irq_agg
  import usb_irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ep0OutReady,
  input  logic              ep0InReady,
  input  logic              ep0SentStall,
  input  logic              ep1InDone,
  input  logic              ep2OutReady,
  input  logic              ep3InDone,
  input  logic              ep3Underrun,
  input  logic              ep4OutReady,
  input  logic              ep4Overflow,
  input  logic              ep4IsoErr,
  input  logic              ep5InDone,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [NUM_EP-1:0] regWrData,
  output logic [NUM_EP-1:0] regRdData,
  output logic [NUM_EP-1:0] statusOut,
  output logic              irq
);
  logic [NUM_COND-1:0] condLvl;
  logic [NUM_COND-1:0] condEdge;
  logic                condPulse [NUM_COND];
  ctlStrobes_t         strobes;
  logic [NUM_EP-1:0]   maskQ;

  always_comb begin
    condLvl              = '0;
    condLvl[C_EP0_OUT]   = ep0OutReady;
    condLvl[C_EP0_IN]    = ep0InReady;
    condLvl[C_EP0_STALL] = ep0SentStall;
    condLvl[C_EP1_IN]    = ep1InDone;
    condLvl[C_EP2_OUT]   = ep2OutReady;
    condLvl[C_EP3_IN]    = ep3InDone;
    condLvl[C_EP3_UND]   = ep3Underrun;
    condLvl[C_EP4_OUT]   = ep4OutReady;
    condLvl[C_EP4_OVF]   = ep4Overflow;
    condLvl[C_EP4_ISO]   = ep4IsoErr;
    condLvl[C_EP5_IN]    = ep5InDone;
  end

  usb_irq_edge_det #(.WIDTH(NUM_COND), .FALL_MASK(FALL_SEL)) u_edge (
    .clk(clk), .rstN(rstN), .lvl(condLvl), .pulse(condEdge)
  );

  for (genvar k = 0; k < NUM_COND; k++) begin : g_unpack
    assign condPulse[k] = condEdge[k];
  end

  usb_irq_ctrl u_ctrl (
    .condPulse(condPulse), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobes(strobes)
  );

  usb_irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .statusQ(statusOut), .maskQ(maskQ), .rdData(regRdData), .irqOut(irq)
  );
endmodule

// File: rtl/usb_ep_irq_agg_chk.sv
module usb_ep_irq_agg_chk
  import usb_irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [NUM_EP-1:0] regWrData,
  input logic [NUM_EP-1:0] statusOut,
  input logic [NUM_EP-1:0] maskQ,
  input logic              irq
);
  logic [NUM_EP-1:0] clrSeen;
  assign clrSeen = (regWrEn && !regAddr) ? regWrData : '0;

  // R2: reset leaves status empty and every endpoint masked
  assert_reset_state_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (statusOut == '0 && maskQ == '1));

  // R1: the request only drops after a status write
  assert_irq_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regWrEn && !regAddr));

  // R3: a bit can only rise when its mask was clear
  assert_masked_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((statusOut & ~$past(statusOut)) & $past(maskQ)) == '0);

  // R4: a bit can only fall when a one was written to it
  assert_w1c_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusOut) & ~statusOut) & ~$past(clrSeen)) == '0);
endmodule

bind usb_ep_irq_agg usb_ep_irq_agg_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .statusOut(statusOut), .maskQ(maskQ), .irq(irq)
);

// File: tb/usb_ep_irq_agg_bench.sv
module usb_ep_irq_agg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] cond = '0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [5:0]  regWrData = '0;
  logic [5:0]  regRdData;
  logic [5:0]  statusOut;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side condition positions
  localparam int B_EP0_IN = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_irq_agg u_usb_ep_irq_agg (
    .clk(clk), .rstN(rstN),
    .ep0OutReady(cond[0]), .ep0InReady(cond[1]), .ep0SentStall(cond[2]),
    .ep1InDone(cond[3]), .ep2OutReady(cond[4]), .ep3InDone(cond[5]),
    .ep3Underrun(cond[6]), .ep4OutReady(cond[7]), .ep4Overflow(cond[8]),
    .ep4IsoErr(cond[9]), .ep5InDone(cond[10]),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .statusOut(statusOut), .irq(irq)
  );

  function automatic int epOf(int idx);
    case (idx)
      0, 1, 2: return 0;
      3:       return 1;
      4:       return 2;
      5, 6:    return 3;
      7, 8, 9: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [5:0] evtOf(logic [10:0] cur, logic [10:0] prv);
    logic [5:0] e = '0;
    for (int i = 0; i < 11; i++) begin
      if (i == B_EP0_IN) begin
        if (prv[i] && !cur[i]) e[epOf(i)] = 1'b1;
      end else if (cur[i] && !prv[i]) e[epOf(i)] = 1'b1;
    end
    return e;
  endfunction

  // reference model
  logic [5:0]  mStatus, mMask;
  logic [10:0] mPrev;
  always @(posedge clk) begin
    if (!rstN) begin
      mStatus = '0; mMask = '1; mPrev = '0;
    end else begin
      logic [5:0] clr;
      clr = (regWrEn && !regAddr) ? regWrData : '0;
      mStatus = (mStatus & ~clr) | (evtOf(cond, mPrev) & ~mMask);
      if (regWrEn && regAddr) mMask = regWrData;
      mPrev = cond;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrReg(logic a, logic [5:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0; regAddr = 1'b0; regWrData = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R2 / R11 reset state
    chk("R2 status after reset", statusOut, 6'h00);
    chk("R2 irq after reset", irq, 1'b0);
    regAddr = 1'b1; #1;
    chk("R2 R11 mask reads all ones", regRdData, 6'h3F);
    regAddr = 1'b0; #1;
    chk("R11 status read", regRdData, 6'h00);

    // R3 masked event does not set
    cond[4] = 1'b1; step();
    chk("R3 masked event ignored", statusOut, 6'h00);

    // R10 unmask with condition held high
    wrReg(1'b1, 6'h00);
    regAddr = 1'b1; #1;
    chk("R11 mask write readback", regRdData, 6'h00);
    regAddr = 1'b0;
    step();
    chk("R10 unmask does not set", statusOut, 6'h00);
    cond[4] = 1'b0; step();

    // R5 endpoint 0 conditions
    cond[1] = 1'b1; step();
    chk("R5 ep0 in-ready rise no event", statusOut, 6'h00);
    cond[1] = 1'b0; step();
    chk("R5 ep0 in-ready fall sets", statusOut, 6'h01);
    chk("R1 irq high", irq, 1'b1);
    wrReg(1'b0, 6'h01);
    chk("R4 clear bit0", statusOut, 6'h00);
    chk("R1 irq low after clear", irq, 1'b0);

    // R5 R6 R7 every rising condition
    for (int i = 0; i < 11; i++) begin
      if (i == B_EP0_IN) continue;
      cond[i] = 1'b1; step();
      chk($sformatf("R5 R6 R7 cond %0d sets bit", i), statusOut, 6'(1) << epOf(i));
      cond[i] = 1'b0;
      wrReg(1'b0, 6'h3F);
      chk($sformatf("R4 cleared after cond %0d", i), statusOut, 6'h00);
    end

    // R4 partial clear
    cond = 11'h7FD; step();
    chk("R7 all set", statusOut, 6'h3F);
    wrReg(1'b0, 6'h05);
    chk("R4 zero bits untouched", statusOut, 6'h3A);

    // R8 held condition not re-set
    wrReg(1'b0, 6'h3F);
    repeat (4) step();
    chk("R8 held conditions stay cleared", statusOut, 6'h00);
    cond = '0; step();

    // R9 set beats clear
    cond[6] = 1'b1; step();
    chk("R9 prep bit3", statusOut, 6'h08);
    cond[6] = 1'b0; cond[5] = 1'b1;
    wrReg(1'b0, 6'h08);
    chk("R9 set wins over clear", statusOut, 6'h08);
    cond = '0;
    wrReg(1'b0, 6'h3F);

    // R3 mask one bit then event
    wrReg(1'b1, 6'h04);
    cond[4] = 1'b1; cond[3] = 1'b1; step();
    chk("R3 only unmasked bit sets", statusOut, 6'h02);
    cond = '0; step();

    // random phase against model
    for (int n = 0; n < 4000; n++) begin
      logic [10:0] flip;
      chk("R1 R3 R4 random status", statusOut, mStatus);
      chk("R1 random irq", irq, |mStatus);
      chk("R11 random read", regRdData, regAddr ? mMask : mStatus);
      flip = 11'($urandom) & 11'($urandom) & 11'($urandom);
      cond = cond ^ flip;
      regWrEn = ($urandom % 4) == 0;
      regAddr = ($urandom % 8) == 0;
      regWrData = 6'($urandom);
      #1;
      step();
    end
    finishRun();
  end
endmodule